// File: doc/BRIEF.md
# Single-Channel DMA Engine with Bus-Error Retry

This block is one bus-master channel that walks a buffer through memory over a 16-bit data bus. Each memory cycle is either a 16-bit (wide) cycle or an 8-bit (byte) cycle. The choice is made per cycle from three things: the current address parity, the bytes still to move, and a byte-only mode bit. The engine supplies the address, width and lane enables. Moving the data between the bus and the peripheral FIFO is left to the surrounding logic.

Every cycle ends at the first of two events: a one-clock acknowledge pulse, or a one-clock bus-error pulse. The acknowledge can optionally pass through a two-flop synchronizer. A bus error spends one unit of a host-loadable retry budget and the same cycle is reissued. Once the budget is empty, the next error raises an interrupt and parks the channel. The channel stays parked until the host acknowledges, and the host may reload the budget first.

Top module: `dma_retry_engine`

## Requirements
- R1: With byte-only mode clear, a cycle is wide (`bus_wide`=1) exactly when the current address is even and at least two bytes remain; otherwise it is a byte cycle.
- R2: With byte-only mode set, every cycle is a byte cycle.
- R3: `bus_be` bit 0 is the low lane. A wide cycle drives 2'b11. A byte cycle drives 2'b10 when address bit 0 XOR `byte_swap` is 1, and 2'b01 otherwise.
- R4: After an acknowledged cycle, the address advances by the bytes moved (1 or 2) and the remaining count drops by the same amount. When it reaches zero, `done` pulses for one clock with `busy` low. A start with length zero pulses `done` on the next clock and issues no bus cycle.
- R5: With mode bit 7 set, the acknowledge passes through two flops, so the next cycle's `bus_strobe` comes three clocks after the acknowledged strobe instead of one.
- R6: Mode register (`cfg_sel`=0) is write-only: bit 7 enables the synchronizer and bit 3 enables byte-only mode. Writes to bits 6:4 and 2:0 have no effect. A read returns 8'h00.
- R7: Retry register (`cfg_sel`=1) is an 8-bit read/write value that resets to zero.
- R8: A bus error with a nonzero retry count decrements the count by one and reissues the same address and width, with `bus_strobe` raised again.
- R9: A bus error with a zero retry count sets `irq`, drops `bus_req` and keeps `busy` high until released.
- R10: `host_ack` while suspended clears `irq` and reissues the failed cycle, using any retry count the host loaded meanwhile. At other times `host_ack` has no effect.
- R11: `xfer_start` is ignored while the channel is busy.
- R12: After reset, `busy`, `irq`, `done` and `bus_req` are low and the retry count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 mode, 1 retry count |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_sel` |
| xfer_start | input | 1 | Start a buffer transfer |
| xfer_addr | input | AW | Buffer start address |
| xfer_len | input | LW | Buffer length in bytes |
| byte_swap | input | 1 | Lane swap for byte cycles |
| bus_req | output | 1 | Bus cycle in progress |
| bus_strobe | output | 1 | First clock of each issued cycle |
| bus_addr | output | AW | Byte address of the cycle |
| bus_wide | output | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| bus_be | output | 2 | Lane enables |
| bus_ack | input | 1 | Cycle acknowledge pulse |
| bus_err | input | 1 | Bus error pulse |
| host_ack | input | 1 | Host service acknowledge |
| busy | output | 1 | Transfer active or suspended |
| done | output | 1 | One-clock end-of-buffer pulse |
| irq | output | 1 | Retry budget exhausted, channel suspended |

## Verification
The bench builds the engine with its defaults: 16-bit addresses, a 12-bit length, 8-bit registers and two synchronizer stages. The two-stage chain is what makes the three-clock strobe spacing of R5 measurable against the one-clock spacing without synchronization. The 16-bit address space lets the vectors start buffers at odd and even addresses across several pages. Short lengths of zero to eight bytes are enough to reach every width-selection edge: an odd start, a lone trailing byte, and byte-only mode.

// File: rtl/dma_retry_pkg.sv
// Package: shared state encoding and register layout for the DMA retry engine.
// Assumes: included first in compile order.
package dma_retry_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

    localparam int unsigned MODE_SYNC_BIT = 7;
    localparam int unsigned MODE_BYTE_BIT = 3;
    localparam logic [7:0]  MODE_LIVE_MASK = 8'h88;

    localparam logic CFG_SEL_MODE  = 1'b0;
    localparam logic CFG_SEL_RETRY = 1'b1;

endpackage

// File: rtl/dma_cfg_regs.sv
// Module: host-visible mode and retry-count registers.
// The mode register keeps only its live bits and reads back as zero. The
// retry count is read/write and is decremented by the sequencer on a retried
// error. A host write wins over a decrement in the same clock.
// Assumes: REG_W <= 8, synchronous active-low reset.
module dma_cfg_regs
    import dma_retry_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [7:0]       wdata,
    input  logic             retry_dec,
    output logic [7:0]       rdata,
    output logic             sync_en,
    output logic             byte_only,
    output logic             retry_nz,
    output logic [REG_W-1:0] retry_cnt
);

    logic [7:0]       mode_q;
    logic [REG_W-1:0] retry_q;

    // Mode register: store only the live bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en && sel == CFG_SEL_MODE) begin
            mode_q <= wdata & MODE_LIVE_MASK;
        end
    end

    // Retry count: host load, else decrement on a retried error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= '0;
        end else if (wr_en && sel == CFG_SEL_RETRY) begin
            retry_q <= wdata[REG_W-1:0];
        end else if (retry_dec && retry_q != '0) begin
            retry_q <= retry_q - REG_W'(1);
        end
    end

    // Read mux: the mode register is write-only and reads as zero.
    always_comb begin
        rdata = 8'h00;
        if (sel == CFG_SEL_RETRY) begin
            rdata = 8'(retry_q);
        end
    end

    assign sync_en   = mode_q[MODE_SYNC_BIT];
    assign byte_only = mode_q[MODE_BYTE_BIT];
    assign retry_nz  = (retry_q != '0);
    assign retry_cnt = retry_q;

endmodule

// File: rtl/dma_ack_sync.sv
// Module: optional flop chain on the bus acknowledge.
// The chain always runs; sync_en picks its last stage or the raw input.
// Assumes: bus_ack is a one-clock pulse per cycle and STAGES >= 1.
module dma_ack_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic ack_raw,
    output logic ack_eff
);

    logic [STAGES-1:0] pipe_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[0] <= 1'b0;
                else        pipe_q[0] <= ack_raw;
            end
        end else begin : g_next
            // Later stages shift the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[g] <= 1'b0;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign ack_eff = sync_en ? pipe_q[STAGES-1] : ack_raw;

endmodule

// File: rtl/dma_xfer_seq.sv
// Module: transfer sequencer. Holds address and remaining count, picks the
// width of each new cycle, retries or suspends on bus errors, and releases
// on host_ack. A retried cycle keeps the width latched when it was first
// issued.
// Assumes: ack and err are one-clock pulses; err wins over ack in one clock.
module dma_xfer_seq
    import dma_retry_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] start_len,
    input  logic          byte_only,
    input  logic          byte_swap,
    input  logic          ack,
    input  logic          err,
    input  logic          retry_nz,
    input  logic          host_ack,
    output logic          bus_req,
    output logic          bus_strobe,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wide,
    output logic [1:0]    bus_be,
    output logic          retry_dec,
    output logic          busy,
    output logic          done,
    output logic          irq
);

    seq_state_e    state_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic          fresh_q;
    logic          new_q;
    logic          wide_q;
    logic          done_q;
    logic          irq_q;
    logic          running;
    logic          pick_wide;
    logic          cyc_wide;
    logic [LW-1:0] step;

    assign running   = (state_q == SEQ_RUN);
    assign pick_wide = !byte_only && !addr_q[0] && (rem_q > LW'(1));
    assign cyc_wide  = new_q ? pick_wide : wide_q;
    assign step      = cyc_wide ? LW'(2) : LW'(1);

    // Main state, address and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            fresh_q <= 1'b0;
            new_q   <= 1'b0;
            wide_q  <= 1'b0;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        if (start_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= SEQ_RUN;
                            addr_q  <= start_addr;
                            rem_q   <= start_len;
                            fresh_q <= 1'b1;
                            new_q   <= 1'b1;
                        end
                    end
                end
                SEQ_RUN: begin
                    fresh_q <= 1'b0;
                    new_q   <= 1'b0;
                    wide_q  <= cyc_wide;
                    if (err) begin
                        if (retry_nz) begin
                            fresh_q <= 1'b1;
                        end else begin
                            irq_q   <= 1'b1;
                            state_q <= SEQ_HOLD;
                        end
                    end else if (ack) begin
                        addr_q <= addr_q + (cyc_wide ? AW'(2) : AW'(1));
                        rem_q  <= rem_q - step;
                        if (rem_q == step) begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            fresh_q <= 1'b1;
                            new_q   <= 1'b1;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (host_ack) begin
                        irq_q   <= 1'b0;
                        state_q <= SEQ_RUN;
                        fresh_q <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Lane enables from width, address parity and swap.
    always_comb begin
        if (cyc_wide)                    bus_be = 2'b11;
        else if (addr_q[0] ^ byte_swap)  bus_be = 2'b10;
        else                             bus_be = 2'b01;
    end

    assign bus_req    = running;
    assign bus_strobe = running && fresh_q;
    assign bus_addr   = addr_q;
    assign bus_wide   = cyc_wide;
    assign retry_dec  = running && err && retry_nz;
    assign busy       = (state_q != SEQ_IDLE);
    assign done       = done_q;
    assign irq        = irq_q;

endmodule

// File: rtl/dma_retry_engine.sv
// Module: top of the single-channel DMA engine with bus-error retry.
// Connects the registers, the acknowledge synchronizer and the sequencer.
// Assumes: one bus cycle outstanding at a time; ack and err are pulses.
module dma_retry_engine
    import dma_retry_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned LW          = 12,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_sel,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          xfer_start,
    input  logic [AW-1:0] xfer_addr,
    input  logic [LW-1:0] xfer_len,
    input  logic          byte_swap,
    output logic          bus_req,
    output logic          bus_strobe,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wide,
    output logic [1:0]    bus_be,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic          host_ack,
    output logic          busy,
    output logic          done,
    output logic          irq
);

    logic             sync_en;
    logic             byte_only;
    logic             retry_nz;
    logic             retry_dec;
    logic             ack_eff;
    logic [REG_W-1:0] retry_cnt;

    dma_cfg_regs #(.REG_W(REG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .retry_dec (retry_dec),
        .rdata     (cfg_rdata),
        .sync_en   (sync_en),
        .byte_only (byte_only),
        .retry_nz  (retry_nz),
        .retry_cnt (retry_cnt)
    );

    dma_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_en (sync_en),
        .ack_raw (bus_ack),
        .ack_eff (ack_eff)
    );

    dma_xfer_seq #(.AW(AW), .LW(LW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xfer_start),
        .start_addr (xfer_addr),
        .start_len  (xfer_len),
        .byte_only  (byte_only),
        .byte_swap  (byte_swap),
        .ack        (ack_eff),
        .err        (bus_err),
        .retry_nz   (retry_nz),
        .host_ack   (host_ack),
        .bus_req    (bus_req),
        .bus_strobe (bus_strobe),
        .bus_addr   (bus_addr),
        .bus_wide   (bus_wide),
        .bus_be     (bus_be),
        .retry_dec  (retry_dec),
        .busy       (busy),
        .done       (done),
        .irq        (irq)
    );

endmodule

// File: rtl/dma_retry_engine_chk.sv
// Module: assertion checker bound to dma_retry_engine.
// Assumes: sees the top's ports plus the register outputs it wires inside.
module dma_retry_engine_chk #(
    parameter int unsigned AW    = 16,
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_sel,
    input logic             bus_req,
    input logic             bus_strobe,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wide,
    input logic [1:0]       bus_be,
    input logic             bus_err,
    input logic             host_ack,
    input logic             busy,
    input logic             done,
    input logic             irq,
    input logic             byte_only,
    input logic             retry_nz,
    input logic [REG_W-1:0] retry_cnt
);

    a_r1_wide_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wide) |-> (!bus_addr[0] && !byte_only));

    a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) == (bus_wide ? 2 : 1)));

    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_strobe) |-> ($stable(bus_addr) && $stable(bus_wide)));

    a_r8_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err && retry_nz) |=>
        (bus_strobe && bus_addr == $past(bus_addr) && bus_wide == $past(bus_wide)));

    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err && retry_nz && !(cfg_wr && cfg_sel)) |=>
        (retry_cnt == $past(retry_cnt) - REG_W'(1)));

    a_r9_err_zero_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err && !retry_nz) |=> irq);

    a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!bus_req && busy));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && host_ack) |=> (!irq && bus_strobe));

endmodule

bind dma_retry_engine dma_retry_engine_chk #(.AW(AW), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .bus_req    (bus_req),
    .bus_strobe (bus_strobe),
    .bus_addr   (bus_addr),
    .bus_wide   (bus_wide),
    .bus_be     (bus_be),
    .bus_err    (bus_err),
    .host_ack   (host_ack),
    .busy       (busy),
    .done       (done),
    .irq        (irq),
    .byte_only  (byte_only),
    .retry_nz   (retry_nz),
    .retry_cnt  (retry_cnt)
);

// File: tb/dma_retry_engine_tb.sv
module dma_retry_engine_tb;

    localparam int AW = 16;
    localparam int LW = 12;

    typedef struct packed {
        logic [15:0] addr;
        logic [11:0] len;
        logic        bm;
        logic        sync;
        logic        swap;
        logic [7:0]  ncyc;
        logic [7:0]  nwide;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{16'h0100, 12'd8, 1'b0, 1'b0, 1'b0, 8'd4, 8'd4},
        '{16'h0101, 12'd6, 1'b0, 1'b0, 1'b1, 8'd4, 8'd2},
        '{16'h0200, 12'd5, 1'b1, 1'b0, 1'b0, 8'd5, 8'd0},
        '{16'h0300, 12'd7, 1'b0, 1'b1, 1'b0, 8'd4, 8'd3},
        '{16'h00FF, 12'd1, 1'b0, 1'b0, 1'b1, 8'd1, 8'd0},
        '{16'h0401, 12'd2, 1'b0, 1'b1, 1'b0, 8'd2, 8'd0},
        '{16'h0500, 12'd0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [7:0]    cfg_wdata = 8'h00;
    logic [7:0]    cfg_rdata;
    logic          xfer_start = 1'b0;
    logic [AW-1:0] xfer_addr = '0;
    logic [LW-1:0] xfer_len = '0;
    logic          byte_swap = 1'b0;
    logic          bus_req, bus_strobe, bus_wide;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_be;
    logic          bus_ack = 1'b0;
    logic          bus_err = 1'b0;
    logic          host_ack = 1'b0;
    logic          busy, done, irq;

    int n_chk = 0;
    int n_err = 0;

    // bench model of the transfer
    logic [AW-1:0] m_addr;
    int            m_rem;
    logic          m_bm;
    int            inj = 0;
    int            n_cyc, n_wide, n_berr;
    int            tick = 0;
    int            last_strobe = -1;
    int            last_gap = 0;

    always #10 clk = ~clk;

    dma_retry_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_start(xfer_start),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .byte_swap(byte_swap),
        .bus_req(bus_req), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_be(bus_be), .bus_ack(bus_ack),
        .bus_err(bus_err), .host_ack(host_ack), .busy(busy), .done(done),
        .irq(irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus slave and per-cycle model check, acting on falling edges.
    always @(negedge clk) begin
        logic       ew;
        logic [1:0] ebe;
        tick++;
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (rst_n && bus_strobe) begin
            n_cyc++;
            if (last_strobe >= 0) last_gap = tick - last_strobe;
            last_strobe = tick;
            ew  = !m_bm && !m_addr[0] && (m_rem > 1);
            ebe = ew ? 2'b11 : ((m_addr[0] ^ byte_swap) ? 2'b10 : 2'b01);
            check(bus_addr == m_addr, "R4 address", 32'(bus_addr), 32'(m_addr));
            check(bus_wide == ew, m_bm ? "R2 width" : "R1 width",
                  32'(bus_wide), 32'(ew));
            check(bus_be == ebe, "R3 lanes", 32'(bus_be), 32'(ebe));
            if (inj > 0) begin
                bus_err = 1'b1;
                inj--;
                n_berr++;
            end else begin
                bus_ack = 1'b1;
                if (ew) n_wide++;
                m_addr = m_addr + (ew ? 16'd2 : 16'd1);
                m_rem  = m_rem - (ew ? 2 : 1);
            end
        end
    end

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic kick(input logic [15:0] a, input int len, input logic bm);
        m_addr = a; m_rem = len; m_bm = bm;
        n_cyc = 0; n_wide = 0; n_berr = 0; last_strobe = -1; last_gap = 0;
        @(negedge clk);
        xfer_start = 1'b1; xfer_addr = a; xfer_len = LW'(len);
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 400 && !got; i++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit         got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check(!busy && !irq && !done && !bus_req, "R12 reset outputs",
              {busy, irq, done, bus_req}, 0);
        cfg_read(1'b1, rd);
        check(rd == 8'h00, "R12 R7 retry reset", rd, 8'h00);

        // Table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            cfg_write(1'b0, {VEC[v].sync, 3'b000, VEC[v].bm, 3'b000});
            byte_swap = VEC[v].swap;
            kick(VEC[v].addr, int'(VEC[v].len), VEC[v].bm);
            wait_done(got);
            check(got, "R4 done pulse", 32'(got), 1);
            check(!busy, "R4 idle after done", 32'(busy), 0);
            check(n_cyc == int'(VEC[v].ncyc), "R4 cycle count", n_cyc, VEC[v].ncyc);
            check(n_wide == int'(VEC[v].nwide), "R1 wide count", n_wide, VEC[v].nwide);
            if (VEC[v].ncyc > 1)
                check(last_gap == (VEC[v].sync ? 3 : 1), "R5 strobe spacing",
                      last_gap, VEC[v].sync ? 3 : 1);
        end
        byte_swap = 1'b0;

        // R6 mode reads zero; reserved bits ignored
        cfg_write(1'b0, 8'hFF);
        cfg_read(1'b0, rd);
        check(rd == 8'h00, "R6 mode read", rd, 8'h00);
        cfg_write(1'b0, 8'h77);
        kick(16'h0600, 4, 1'b0);
        wait_done(got);
        check(got && n_wide == 2, "R6 reserved ignored wide", n_wide, 2);
        check(last_gap == 1, "R6 reserved ignored sync", last_gap, 1);

        // R7 retry read/write
        cfg_write(1'b1, 8'hA5);
        cfg_read(1'b1, rd);
        check(rd == 8'hA5, "R7 retry readback", rd, 8'hA5);

        // R8 retried errors
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'd2);
        inj = 2;
        kick(16'h0700, 2, 1'b0);
        wait_done(got);
        check(got && n_cyc == 3, "R8 reissue count", n_cyc, 3);
        check(!irq, "R8 no irq", 32'(irq), 0);
        cfg_read(1'b1, rd);
        check(rd == 8'd0, "R8 count decremented", rd, 0);

        // R9 suspend on empty budget
        inj = 1;
        kick(16'h0800, 4, 1'b0);
        repeat (6) @(negedge clk);
        check(irq && busy && !bus_req, "R9 suspended", {irq, busy, bus_req}, 3'b110);
        check(n_cyc == 1, "R9 no new cycle while suspended", n_cyc, 1);

        // R10 reload then release
        cfg_write(1'b1, 8'd1);
        inj = 1;
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
        check(!irq, "R10 irq cleared", 32'(irq), 0);
        wait_done(got);
        check(got && n_cyc == 4, "R10 resumed cycles", n_cyc, 4);
        check(n_berr == 2 && !irq, "R10 reloaded budget used", n_berr, 2);
        cfg_read(1'b1, rd);
        check(rd == 8'd0, "R10 count after retry", rd, 0);
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
        check(!irq && !busy && !bus_req, "R10 host_ack ignored when idle",
              {irq, busy, bus_req}, 0);

        // R11 start ignored while busy
        kick(16'h0900, 6, 1'b0);
        @(negedge clk);
        xfer_start = 1'b1; xfer_addr = 16'h0A00; xfer_len = 12'd2;
        @(negedge clk);
        xfer_start = 1'b0;
        wait_done(got);
        check(got && n_cyc == 3 && n_wide == 3, "R11 busy start ignored", n_cyc, 3);
        check(m_addr == 16'h0906, "R11 final address", 32'(m_addr), 32'h0906);
        repeat (3) @(negedge clk);
        check(!busy && n_cyc == 3, "R11 no second transfer", n_cyc, 3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule